// File: doc/BRIEF.md
# Wrap-aware burst read port for a single-port memory bank

This block serves AXI read bursts on a 128-bit data bus from one synchronous single-port memory bank. It accepts one burst request at a time on the read-address channel and works out the byte address of every beat for incrementing, wrapping and fixed bursts. It returns each beat on the read-data channel. Data bytes reach the bus lanes that the beat address selects, and every other lane is driven to zero.

The port keeps the most recently fetched 128-bit memory word in a holding register, tagged with its word index. A beat whose word matches the held tag is answered from that register, and the memory is not touched. This holds across the beats of one burst and across consecutive bursts. A wrapping burst that comes back into the word it started in therefore costs one memory read, not two.

A plain `write_hit` input tells the port that the bank has been written. It drops the held word so that the next beat fetches fresh data. A free-running read counter lets the environment measure how many memory accesses a traffic pattern caused.

Both stream interfaces follow valid/ready rules:
- A request is taken in a cycle where `ar_valid` and `ar_ready` are both high.
- A beat moves in a cycle where `r_valid` and `r_ready` are both high.
- While `r_ready` is low, the offered beat and all its fields stay unchanged.

Top module: `axi_wrap_rd_port`

## Requirements
- R1: After reset `ar_ready` is 1, and `r_valid`, `mem_en` and `rd_count` are 0. `ar_ready` is high only while no burst is in progress, and it drops in the cycle after a request is accepted.
- R2: Burst encodings are `ar_burst` 2'b01 incrementing, 2'b10 wrapping and 2'b00 fixed; 2'b11 is served as incrementing. `ar_len` is the beat count minus one (0..15), and `ar_size` is log2 of the bytes per beat (0..4). For an incrementing burst, beat 0 is at `ar_addr` and each later beat is at the previous address rounded down to the transfer size plus 2^`ar_size`.
- R3: For a wrapping burst, the address advances as in R2 but stays inside a window of (`ar_len`+1)·2^`ar_size` bytes aligned to its own size. With start 0x22, 1-byte beats and four beats, the beats fall on 0x22, 0x23, 0x20 and 0x21.
- R4: For a fixed burst, every beat uses `ar_addr`.
- R5: Memory word w holds bytes 16w to 16w+15, and byte 16w+i travels on lane i (`r_data[8i+7:8i]`). For a beat at address a, lane i carries data only when a[3:0] ≤ i < (a[3:0] rounded down to the transfer size) + 2^`ar_size`. All other lanes are zero.
- R6: A memory read is issued for a beat only when no word is held, or the held word index differs from the beat's word index (address bits above bit 3). A wrap burst that stays within one word costs exactly one read. A burst to the word held from the previous burst costs none.
- R7: A `write_hit` pulse drops the held word. A lookup in the same cycle as `write_hit` counts as a miss. If `write_hit` coincides with the cycle a fetched word is captured, the word is returned for its beat but is not held afterwards.
- R8: While `r_valid` is high and `r_ready` is low, `r_data` and `r_last` stay stable, even if `write_hit` arrives during the stall.
- R9: A burst returns exactly `ar_len`+1 beats, with `r_last` high on the final one only. `r_resp` is always 2'b00.
- R10: `mem_addr` carries the word index while `mem_en` is high. `mem_rdata` is taken one cycle later. `mem_en` is never high in two consecutive cycles. `rd_count` rises by one for each cycle with `mem_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_valid | input | 1 | Burst request valid |
| ar_ready | output | 1 | Port idle and able to take a request |
| ar_addr | input | 16 | Byte address of the first beat |
| ar_len | input | 4 | Beats minus one |
| ar_size | input | 3 | log2 of bytes per beat |
| ar_burst | input | 2 | Burst type |
| r_valid | output | 1 | Beat valid |
| r_ready | input | 1 | Beat accepted by the receiver |
| r_data | output | 128 | Beat data, unused lanes zero |
| r_last | output | 1 | Final beat of the burst |
| r_resp | output | 2 | Response code, always 2'b00 |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory word index |
| mem_rdata | input | 128 | Memory word, valid the cycle after `mem_en` |
| write_hit | input | 1 | The bank was written; drop the held word |
| rd_count | output | 16 | Number of memory reads issued, wrapping |

## Verification
Invalidation by `write_hit` can land in the same cycle as two other events. One is the capture of a freshly fetched word. The other is the tag lookup for the next beat.

The bench provokes the first case by pulsing `write_hit` in the cycle after it sees `mem_en`. It expects the old data on that beat and a second read for the following beat in the same word. It provokes the second case by pulsing `write_hit` right after a beat is accepted. It then requires a read for the next beat, even though the tag matches. A third case pulses `write_hit` while a beat is stalled by `r_ready`. Here the offered data must stay frozen, and the next beat must refetch.

Each case is judged by comparing returned bytes against generation-stamped memory contents and by counting `mem_en` cycles against a model of the holding register.

// File: rtl/arp_pkg.sv
package arp_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_BEAT
  } state_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/arp_beat_addr.sv
module arp_beat_addr import arp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  burst_e            burst,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] next_addr
);

  logic [ADDR_W-1:0] nbytes;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] span_m;

  always_comb begin
    nbytes  = ADDR_W'(1) << size;
    aligned = cur_addr & ~(nbytes - ADDR_W'(1));
    stepped = aligned + nbytes;
    span    = nbytes * (ADDR_W'(len) + ADDR_W'(1));
    span_m  = span - ADDR_W'(1);
    unique case (burst)
      BURST_FIXED: next_addr = cur_addr;
      BURST_WRAP:  next_addr = (cur_addr & ~span_m) | (stepped & span_m);
      default:     next_addr = stepped;
    endcase
  end

endmodule

// File: rtl/arp_lane_mask.sv
module arp_lane_mask #(
  parameter int BYTES = 16,
  parameter int OFF_W = 4
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [2:0]       size,
  output logic [BYTES-1:0] lane_en
);

  localparam int LW = OFF_W + 1;

  logic [LW-1:0] nb;
  logic [LW-1:0] lo;
  logic [LW-1:0] base;
  logic [LW-1:0] hi;

  always_comb begin
    nb   = LW'(1) << size;
    lo   = {1'b0, offset};
    base = lo & ~(nb - LW'(1));
    hi   = base + nb;
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_en[g] = (LW'(g) >= lo) && (LW'(g) < hi);
  end

endmodule

// File: rtl/arp_word_hold.sv
module arp_word_hold #(
  parameter int WORD_W = 12,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_tag,
  input  logic [DATA_W-1:0] load_data,
  input  logic              inval,
  input  logic [WORD_W-1:0] lookup_tag,
  output logic              hit,
  output logic [DATA_W-1:0] held_data
);

  logic              valid_q;
  logic [WORD_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      tag_q     <= '0;
      held_data <= '0;
    end else begin
      if (inval)     valid_q <= 1'b0;
      else if (load) valid_q <= 1'b1;
      if (load) begin
        tag_q     <= load_tag;
        held_data <= load_data;
      end
    end
  end

  assign hit = valid_q && !inval && (tag_q == lookup_tag);

endmodule

// File: rtl/axi_wrap_rd_port.sv
module axi_wrap_rd_port import arp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 128,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ar_valid,
  output logic                                ar_ready,
  input  logic [ADDR_W-1:0]                   ar_addr,
  input  logic [LEN_W-1:0]                    ar_len,
  input  logic [2:0]                          ar_size,
  input  logic [1:0]                          ar_burst,
  output logic                                r_valid,
  input  logic                                r_ready,
  output logic [DATA_W-1:0]                   r_data,
  output logic                                r_last,
  output logic [1:0]                          r_resp,
  output logic                                mem_en,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_addr,
  input  logic [DATA_W-1:0]                   mem_rdata,
  input  logic                                write_hit,
  output logic [CNT_W-1:0]                    rd_count
);

  localparam int BYTES    = DATA_W / 8;
  localparam int OFF_W    = $clog2(BYTES);
  localparam int WORD_W   = ADDR_W - OFF_W;
  localparam int SIZE_MAX = OFF_W;

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  left_q;
  logic [2:0]        size_q;
  burst_e            burst_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [2:0]        size_in;
  logic [ADDR_W-1:0] next_addr;
  logic [WORD_W-1:0] cur_word;
  logic              hit;
  logic [DATA_W-1:0] held_data;
  logic [BYTES-1:0]  lane_en;
  logic              accept_ar;
  logic              beat_done;

  assign size_in   = (ar_size > 3'(SIZE_MAX)) ? 3'(SIZE_MAX) : ar_size;
  assign cur_word  = addr_q[ADDR_W-1:OFF_W];
  assign accept_ar = (state_q == ST_IDLE) && ar_valid;
  assign beat_done = (state_q == ST_BEAT) && r_ready;

  arp_beat_addr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) i_beat_addr (
    .cur_addr  (addr_q),
    .size      (size_q),
    .burst     (burst_q),
    .len       (len_q),
    .next_addr (next_addr)
  );

  arp_word_hold #(
    .WORD_W (WORD_W),
    .DATA_W (DATA_W)
  ) i_word_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (state_q == ST_WAIT),
    .load_tag   (cur_word),
    .load_data  (mem_rdata),
    .inval      (write_hit),
    .lookup_tag (cur_word),
    .hit        (hit),
    .held_data  (held_data)
  );

  arp_lane_mask #(
    .BYTES (BYTES),
    .OFF_W (OFF_W)
  ) i_lane_mask (
    .offset  (addr_q[OFF_W-1:0]),
    .size    (size_q),
    .lane_en (lane_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      left_q  <= '0;
      size_q  <= '0;
      burst_q <= BURST_INCR;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_ar) begin
            addr_q  <= ar_addr;
            len_q   <= ar_len;
            left_q  <= ar_len;
            size_q  <= size_in;
            burst_q <= burst_e'(ar_burst);
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= hit ? ST_BEAT : ST_WAIT;
        ST_WAIT:  state_q <= ST_BEAT;
        ST_BEAT: begin
          if (beat_done) begin
            if (left_q == '0) begin
              state_q <= ST_IDLE;
            end else begin
              addr_q  <= next_addr;
              left_q  <= left_q - LEN_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (mem_en) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign ar_ready = (state_q == ST_IDLE);
  assign mem_en   = (state_q == ST_ISSUE) && !hit;
  assign mem_addr = cur_word;
  assign rd_count = cnt_q;
  assign r_valid  = (state_q == ST_BEAT);
  assign r_last   = r_valid && (left_q == '0);
  assign r_resp   = RESP_OKAY;

  for (genvar g = 0; g < BYTES; g++) begin : g_steer
    assign r_data[8*g +: 8] = lane_en[g] ? held_data[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/arp_chk.sv
module arp_chk #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic              r_last,
  input logic [1:0]        r_resp,
  input logic              mem_en,
  input logic [CNT_W-1:0]  rd_count
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_ready |-> (!r_valid && !mem_en));

  // R1
  ar_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !ar_ready);

  // R8
  r_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last)));

  // R9
  r_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (r_resp == 2'b00));

  // R9
  r_last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_ready && r_last) |=> ar_ready);

  // R10
  mem_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);

  // R10
  rd_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> (rd_count == $past(rd_count) + CNT_W'(1)));

  // R10
  rd_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |=> $stable(rd_count));

endmodule

bind axi_wrap_rd_port arp_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) i_arp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ar_valid (ar_valid),
  .ar_ready (ar_ready),
  .r_valid  (r_valid),
  .r_ready  (r_ready),
  .r_data   (r_data),
  .r_last   (r_last),
  .r_resp   (r_resp),
  .mem_en   (mem_en),
  .rd_count (rd_count)
);

// File: tb/test_axi_wrap_rd_port.sv
`timescale 1ns/1ps
module test_axi_wrap_rd_port;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ar_valid = 1'b0;
  logic         ar_ready;
  logic [15:0]  ar_addr = '0;
  logic [3:0]   ar_len = '0;
  logic [2:0]   ar_size = '0;
  logic [1:0]   ar_burst = 2'b01;
  logic         r_valid;
  logic         r_ready = 1'b0;
  logic [127:0] r_data;
  logic         r_last;
  logic [1:0]   r_resp;
  logic         mem_en;
  logic [11:0]  mem_addr;
  logic [127:0] mem_rdata = '0;
  logic         write_hit = 1'b0;
  logic [15:0]  rd_count;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  gen = 8'h00;
  bit          m_valid = 1'b0;
  logic [11:0] m_word = '0;
  logic [7:0]  m_gen = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  axi_wrap_rd_port i_axi_wrap_rd_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .ar_valid  (ar_valid),
    .ar_ready  (ar_ready),
    .ar_addr   (ar_addr),
    .ar_len    (ar_len),
    .ar_size   (ar_size),
    .ar_burst  (ar_burst),
    .r_valid   (r_valid),
    .r_ready   (r_ready),
    .r_data    (r_data),
    .r_last    (r_last),
    .r_resp    (r_resp),
    .mem_en    (mem_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .write_hit (write_hit),
    .rd_count  (rd_count)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a, input logic [7:0] g);
    return (a[7:0] * 8'd29) + (a[15:8] * 8'd7) + (g * 8'd101) + 8'd13;
  endfunction

  function automatic logic [127:0] word_val(input logic [11:0] w, input logic [7:0] g);
    logic [127:0] d;
    for (int i = 0; i < 16; i++) d[8*i +: 8] = byte_at({w, 4'(i)}, g);
    return d;
  endfunction

  // one-cycle memory model
  always @(posedge clk) if (mem_en) mem_rdata <= word_val(mem_addr, gen);

  function automatic logic [15:0] beat_addr(input logic [15:0] a, input logic [3:0] len,
                                            input logic [2:0] size, input logic [1:0] burst,
                                            input int i);
    int nb;
    int span;
    int st;
    int lowb;
    nb   = 1 << size;
    span = nb * (int'(len) + 1);
    st   = int'(a);
    if (burst == 2'b00) return a;
    if (burst == 2'b10) begin
      lowb = st - (st % span);
      return 16'(lowb + ((st - lowb + i * nb) % span));
    end
    if (i == 0) return a;
    return 16'((st - (st % nb)) + i * nb);
  endfunction

  function automatic logic [127:0] lane_bits(input logic [15:0] a, input logic [2:0] size);
    int nb;
    int lo;
    int hi;
    logic [127:0] m;
    nb = 1 << size;
    lo = int'(a[3:0]);
    hi = (lo - (lo % nb)) + nb;
    m  = '0;
    for (int i = 0; i < 16; i++) if (i >= lo && i < hi) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_beat(input logic [15:0] ba, output int add);
    add = 0;
    if (!(m_valid && m_word == ba[15:4])) begin
      add     = 1;
      m_valid = 1'b1;
      m_word  = ba[15:4];
      m_gen   = gen;
    end
  endtask

  task automatic pulse_write;
    write_hit = 1'b1;
    gen       = gen + 8'd1;
    m_valid   = 1'b0;
    @(negedge clk);
    write_hit = 1'b0;
  endtask

  // wh_mode: 0 none, 1 write_hit while first fetched word is captured,
  // 2 write_hit during a stall of beat 0, 3 write_hit on the lookup of beat 1
  task automatic run_burst(input logic [15:0] a, input logic [3:0] len, input logic [2:0] size,
                           input logic [1:0] burst, input int wh_mode);
    int beat = 0;
    int exp_reads = 0;
    int seen = 0;
    int add = 0;
    int stall = 0;
    bit done = 1'b0;
    bit armed;
    bit prev_en = 1'b0;
    bit pend = 1'b0;
    bit first = 1'b1;
    bit was_stalled = 1'b0;
    bit rdy;
    logic [127:0] last_d = '0;
    logic last_l = 1'b0;
    logic [15:0] cnt0;
    logic [15:0] ba;
    logic [127:0] ed;
    string tag;
    armed = (wh_mode != 0);
    tag = (burst == 2'b10) ? "R3" : (burst == 2'b00) ? "R4" : "R2";
    cnt0 = rd_count;
    ar_addr = a; ar_len = len; ar_size = size; ar_burst = burst; ar_valid = 1'b1;
    #1;
    chk(ar_ready === 1'b1, "R1", "ar_ready while idle", 128'(ar_ready), 128'd1);
    @(negedge clk);
    ar_valid = 1'b0;
    ba = beat_addr(a, len, size, burst, 0);
    model_beat(ba, add); exp_reads += add;
    ed = word_val(ba[15:4], m_gen) & lane_bits(ba, size);
    while (!done) begin
      write_hit = 1'b0;
      if (pend) begin write_hit = 1'b1; pend = 1'b0; end
      if (wh_mode == 1 && armed && prev_en) begin
        write_hit = 1'b1; armed = 1'b0; gen = gen + 8'd1; m_valid = 1'b0;
      end
      if (wh_mode == 2 && armed && r_valid && stall == 1) begin
        write_hit = 1'b1; armed = 1'b0; gen = gen + 8'd1; m_valid = 1'b0;
      end
      rdy = (wh_mode == 2 && beat == 0 && stall < 3) ? 1'b0 : (lfsr[0] | lfsr[2]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r_ready = rdy;
      #1;
      if (first) begin
        chk(!ar_ready && !r_valid, "R1", "busy after accept", {ar_ready, r_valid}, 128'd0);
        first = 1'b0;
      end
      prev_en = mem_en;
      if (mem_en) begin
        seen++;
        chk(mem_addr == ba[15:4], "R10", "mem_addr word index", 128'(mem_addr), 128'(ba[15:4]));
      end
      if (r_valid && !rdy) begin
        if (was_stalled)
          chk(r_data == last_d && r_last == last_l, "R8", "stalled beat changed",
              r_data, last_d);
        was_stalled = 1'b1; last_d = r_data; last_l = r_last;
        if (beat == 0) stall++;
      end else begin
        was_stalled = 1'b0;
      end
      if (r_valid && rdy) begin
        chk(r_data == ed, tag, "beat data", r_data, ed);
        chk((r_data & ~lane_bits(ba, size)) == '0, "R5", "inactive lanes not zero",
            r_data & ~lane_bits(ba, size), 128'd0);
        chk(r_last == (beat == int'(len)), "R9", "r_last placement", 128'(r_last),
            128'(beat == int'(len)));
        chk(r_resp == 2'b00, "R9", "r_resp", 128'(r_resp), 128'd0);
        if (beat == int'(len)) begin
          done = 1'b1;
        end else begin
          if (wh_mode == 3 && armed && beat == 0) begin
            pend = 1'b1; armed = 1'b0; gen = gen + 8'd1; m_valid = 1'b0;
          end
          beat++;
          ba = beat_addr(a, len, size, burst, beat);
          model_beat(ba, add); exp_reads += add;
          ed = word_val(ba[15:4], m_gen) & lane_bits(ba, size);
        end
      end
      @(negedge clk);
    end
    write_hit = 1'b0;
    r_ready = 1'b0;
    chk(seen == exp_reads, "R6", "memory reads in burst", 128'(seen), 128'(exp_reads));
    chk(16'(rd_count - cnt0) == 16'(exp_reads), "R10", "rd_count delta",
        128'(16'(rd_count - cnt0)), 128'(exp_reads));
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [1:0]  bt;
    logic [3:0]  ln;
    logic [15:0] addr;
    int k;
    int off;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(ar_ready === 1'b1 && r_valid === 1'b0 && mem_en === 1'b0, "R1", "reset outputs",
        {ar_ready, r_valid, mem_en}, 128'b100);
    chk(rd_count === 16'd0, "R10", "reset rd_count", 128'(rd_count), 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 wrap at 0x22, one byte beats, four beats: one read (R6)
    run_burst(16'h0022, 4'd3, 3'd0, 2'b10, 0);
    // R6 back-to-back burst to the held word: zero reads
    run_burst(16'h0024, 4'd0, 3'd0, 2'b01, 0);
    run_burst(16'h0020, 4'd1, 3'd2, 2'b10, 0);
    // R7 invalidation between bursts forces a refetch with new contents
    pulse_write();
    run_burst(16'h0022, 4'd3, 3'd0, 2'b10, 0);
    // R7 write_hit coincides with capture of the fetched word
    pulse_write();
    run_burst(16'h0300, 4'd1, 3'd0, 2'b01, 1);
    // R7 write_hit on the same cycle as the lookup of beat 1
    run_burst(16'h0310, 4'd1, 3'd0, 2'b01, 3);
    // R8 write_hit during a stalled beat
    run_burst(16'h0022, 4'd3, 3'd0, 2'b10, 2);
    // R2 reserved encoding served as incrementing
    run_burst(16'h0405, 4'd7, 3'd1, 2'b11, 0);
    // R4 fixed burst, unaligned
    run_burst(16'h0517, 4'd3, 3'd1, 2'b00, 0);

    // sweep burst type x size x length x start offset
    k = 0;
    for (int b = 0; b < 3; b++) begin
      for (int s = 0; s < 5; s++) begin
        for (int li = 0; li < 5; li++) begin
          for (int o = 0; o < 4; o++) begin
            bt  = (b == 0) ? 2'b01 : (b == 1) ? 2'b10 : 2'b00;
            ln  = (li == 0) ? 4'd0 : (li == 1) ? 4'd1 : (li == 2) ? 4'd3 : (li == 3) ? 4'd7 : 4'd15;
            if (bt == 2'b10 && ln == 4'd0) continue;
            off = (o == 0) ? 0 : (o == 1) ? 6 : (o == 2) ? 11 : 31;
            addr = 16'h0100 + 16'(k) * 16'h0030 + 16'(off);
            if (bt == 2'b10) addr = addr & ~16'((1 << s) - 1);
            run_burst(addr, ln, 3'(s), bt, 0);
            k++;
            if (k % 37 == 0) pulse_write();
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule